// File: doc/BRIEF.md
# MSI to Link Interrupt Translator

This block sits on the upstream path of an I/O bridge and sorts each incoming memory write. Each write carries a 64-bit address and 32-bit data. A write is a message-signalled interrupt when interrupt translation is enabled and its address falls in the configured 1 MiB interrupt window. The block rebuilds such a write into a 64-bit interrupt-info word for the link's interrupt packet. Every other write leaves on a separate posted-write output with its address and data unchanged.

All three streams use valid/ready handshakes. Each output has a single-entry holding slot. The input is stalled only while the slot chosen for the current write is full and cannot drain in that cycle, so no write is lost or reordered within its class. The configuration comes in on plain input pins: the enable bit, 32 upper window bits and 12 lower window bits. A one-cycle error flag marks an interrupt whose delivery mode is unsupported or whose end-of-interrupt request bit is set. Such an interrupt is still translated and sent.

Top module: `msi_irq_xlate`

## Requirements
- R1: An input write is classified as an interrupt exactly when `cfg_msi_en` is 1 and `in_addr[63:20]` equals `{cfg_win_hi, cfg_win_lo}`. It then appears on the interrupt output.
- R2: Any write that fails either condition appears on the posted-write output with `mw_addr`/`mw_data` equal to the input address and data, and it produces no interrupt.
- R3: Destination and vector placement in `irq_info`: [23:16] = data[7:0]; [15:8] = addr[19:12]; [39:32] = addr[11:4]; [50:40] = addr[30:20]; [51] = addr[3]; [55:52] = data[14:11].
- R4: Mode and marker bits in `irq_info`: [6] = addr[2] (destination mode); [5] = data[15] (end-of-interrupt request); [4:2] = data[10:8] (message type); [7] = 0; [31:24] = 8'hF8; [1:0] = 0; [63:56] = 0.
- R5: An interrupt whose message type is neither 3'b000 nor 3'b001, or whose data[15] is 1, is still translated. `fmt_err` is then 1 for exactly the cycle in which that interrupt first shows on `irq_valid`. In all other cycles `fmt_err` is 0.
- R6: While an output's slot holds a word and its ready input is low, `in_ready` is 0 for writes bound to that output, and the held word stays valid and unchanged. Writes bound to the other output are still accepted.
- R7: After reset, `irq_valid`, `mw_valid` and `fmt_err` are 0 and `in_ready` is 1.
- R8: An accepted write is visible on its output in the next cycle. A slot that drains in a cycle can take a new write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_msi_en | input | 1 | Interrupt translation enable |
| cfg_win_hi | input | 32 | Window address bits [63:32] |
| cfg_win_lo | input | 12 | Window address bits [31:20] |
| in_valid | input | 1 | Input write valid |
| in_ready | output | 1 | Input write accepted when high with valid |
| in_addr | input | 64 | Input write address |
| in_data | input | 32 | Input write data |
| irq_valid | output | 1 | Interrupt word valid |
| irq_ready | input | 1 | Interrupt consumer ready |
| irq_info | output | 64 | Translated interrupt-info word |
| mw_valid | output | 1 | Posted write valid |
| mw_ready | input | 1 | Posted write consumer ready |
| mw_addr | output | 64 | Posted write address |
| mw_data | output | 32 | Posted write data |
| fmt_err | output | 1 | One-cycle flag for an unsupported interrupt format |

## Verification
Two things can land in the same cycle. One is the error flag and the appearance of a freshly translated interrupt. The other is the draining of a full interrupt slot and the loading of the next write into it. The first is provoked by vectors with a reserved message type or the end-of-interrupt bit set. It is judged by sampling `fmt_err` together with `irq_valid`/`irq_info` in the cycle after acceptance, and confirming that the flag is gone one cycle later. The second is provoked by holding `irq_ready` low to fill the slot, then raising it in the same cycle as a new interrupt is presented. The bench then checks that `in_ready` was high and that the next cycle shows the new word.

// File: rtl/msi_xlate_pkg.sv
package msi_xlate_pkg;

    localparam int ADDR_W  = 64;
    localparam int DATA_W  = 32;
    localparam int INFO_W  = 64;
    localparam int WIN_LSB = 20;
    localparam int HI_W    = 32;
    localparam int LO_W    = ADDR_W - WIN_LSB - HI_W;

    // slices handed to the packer: addr[30:2] and data[15:0]
    localparam int A_LO = 2;
    localparam int A_HI = 30;
    localparam int PA_W = A_HI - A_LO + 1;
    localparam int PD_W = 16;

    localparam logic [7:0] MARKER = 8'hF8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    typedef enum logic [2:0] {
        MT_FIXED  = 3'b000,
        MT_LOWPRI = 3'b001
    } msg_type_e;

    typedef struct packed {
        logic [7:0]  rsvd_hi;   // [63:56]
        logic [3:0]  dst_31_28; // [55:52]
        logic        dst_27;    // [51]
        logic [10:0] dst_26_16; // [50:40]
        logic [7:0]  dst_15_8;  // [39:32]
        logic [7:0]  marker;    // [31:24]
        logic [7:0]  vector;    // [23:16]
        logic [7:0]  dst_7_0;   // [15:8]
        logic        mt3;       // [7]
        logic        dmode;     // [6]
        logic        eoi_req;   // [5]
        logic [2:0]  mtype;     // [4:2]
        logic [1:0]  rsvd_lo;   // [1:0]
    } info_t;

    function automatic logic mtype_ok(input logic [2:0] mt);
        return (mt == MT_FIXED) || (mt == MT_LOWPRI);
    endfunction

endpackage

// File: rtl/msi_win_match.sv
module msi_win_match
    import msi_xlate_pkg::*;
(
    input  logic [ADDR_W-1:WIN_LSB] addr_top,
    input  logic                    en,
    input  logic [HI_W-1:0]         win_hi,
    input  logic [LO_W-1:0]         win_lo,
    output logic                    hit
);
    logic [ADDR_W-WIN_LSB-1:0] win;

    always_comb begin
        win = {win_hi, win_lo};
        hit = en && (addr_top == win);
    end
endmodule

// File: rtl/msi_info_pack.sv
module msi_info_pack
    import msi_xlate_pkg::*;
(
    input  logic [A_HI:A_LO]  a,
    input  logic [PD_W-1:0]   d,
    output logic [INFO_W-1:0] info,
    output logic              bad_fmt
);
    info_t f;

    always_comb begin
        f           = '0;
        f.rsvd_lo   = 2'b00;
        f.mtype     = d[10:8];
        f.eoi_req   = d[15];
        f.dmode     = a[2];
        f.mt3       = 1'b0;
        f.dst_7_0   = a[19:12];
        f.vector    = d[7:0];
        f.marker    = MARKER;
        f.dst_15_8  = a[11:4];
        f.dst_26_16 = a[30:20];
        f.dst_27    = a[3];
        f.dst_31_28 = d[14:11];
        f.rsvd_hi   = 8'h00;
        info        = f;
        bad_fmt     = d[15] || !mtype_ok(d[10:8]);
    end
endmodule

// File: rtl/msi_out_slot.sv
module msi_out_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    output logic         ld_ok,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic         full;
    logic [W-1:0] hold;

    assign ld_ok     = !full || out_ready;
    assign out_valid = full;
    assign out_data  = hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            hold <= '0;
        end else begin
            if (ld) begin
                full <= 1'b1;
                hold <= ld_data;
            end else if (out_ready) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/msi_irq_xlate.sv
module msi_irq_xlate
    import msi_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_msi_en,
    input  logic [HI_W-1:0]   cfg_win_hi,
    input  logic [LO_W-1:0]   cfg_win_lo,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              irq_valid,
    input  logic              irq_ready,
    output logic [INFO_W-1:0] irq_info,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data,
    output logic              fmt_err
);
    localparam int MW_W = ADDR_W + DATA_W;

    logic              is_irq;
    logic [INFO_W-1:0] info_c;
    logic              bad_c;
    logic              irq_ok, mw_ok, irq_ld, mw_ld;
    wr_t               wr_c, wr_q;

    msi_win_match u_match (
        .addr_top (in_addr[ADDR_W-1:WIN_LSB]),
        .en       (cfg_msi_en),
        .win_hi   (cfg_win_hi),
        .win_lo   (cfg_win_lo),
        .hit      (is_irq)
    );

    msi_info_pack u_pack (
        .a       (in_addr[A_HI:A_LO]),
        .d       (in_data[PD_W-1:0]),
        .info    (info_c),
        .bad_fmt (bad_c)
    );

    always_comb begin
        wr_c.addr = in_addr;
        wr_c.data = in_data;
        in_ready  = is_irq ? irq_ok : mw_ok;
        irq_ld    = in_valid && is_irq && irq_ok;
        mw_ld     = in_valid && !is_irq && mw_ok;
    end

    msi_out_slot #(.W(INFO_W)) u_irq_slot (
        .clk       (clk),
        .rst       (rst),
        .ld_ok     (irq_ok),
        .ld        (irq_ld),
        .ld_data   (info_c),
        .out_valid (irq_valid),
        .out_ready (irq_ready),
        .out_data  (irq_info)
    );

    msi_out_slot #(.W(MW_W)) u_mw_slot (
        .clk       (clk),
        .rst       (rst),
        .ld_ok     (mw_ok),
        .ld        (mw_ld),
        .ld_data   (wr_c),
        .out_valid (mw_valid),
        .out_ready (mw_ready),
        .out_data  (wr_q)
    );

    assign mw_addr = wr_q.addr;
    assign mw_data = wr_q.data;

    always_ff @(posedge clk) begin
        if (rst) fmt_err <= 1'b0;
        else     fmt_err <= irq_ld && bad_c;
    end
endmodule

// File: rtl/msi_irq_xlate_chk.sv
module msi_irq_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        irq_valid,
    input logic        irq_ready,
    input logic [63:0] irq_info,
    input logic        mw_valid,
    input logic        mw_ready,
    input logic [63:0] mw_addr,
    input logic [31:0] mw_data,
    input logic        fmt_err
);
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (rst)
        irq_valid && !irq_ready |=> irq_valid && $stable(irq_info));

    a_r6_mw_hold: assert property (@(posedge clk) disable iff (rst)
        mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

    a_r6_stall_cause: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_ready |-> (irq_valid && !irq_ready) || (mw_valid && !mw_ready));

    a_r8_next_cycle: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> irq_valid || mw_valid);

    a_r5_err_with_irq: assert property (@(posedge clk) disable iff (rst)
        fmt_err |-> irq_valid);

    a_r4_markers: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> irq_info[31:24] == 8'hF8 && irq_info[7] == 1'b0
                      && irq_info[1:0] == 2'b00 && irq_info[63:56] == 8'h00);
endmodule

bind msi_irq_xlate msi_irq_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .irq_valid (irq_valid),
    .irq_ready (irq_ready),
    .irq_info  (irq_info),
    .mw_valid  (mw_valid),
    .mw_ready  (mw_ready),
    .mw_addr   (mw_addr),
    .mw_data   (mw_data),
    .fmt_err   (fmt_err)
);

// File: tb/msi_irq_xlate_tb.sv
module msi_irq_xlate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    localparam logic [63:0] V_ADDR [NV] = '{
        64'h0000_0000_FEE1_2348, 64'h0000_0000_FEEA_BCD4,
        64'h0000_0000_FEE5_5550, 64'h0000_0000_FEE0_0A0C,
        64'h0000_0001_FEE0_0000, 64'h0000_0000_FEF0_0010,
        64'h0000_0000_FEEF_FFFC, 64'h8000_0000_FEE0_0000};
    localparam logic [31:0] V_DATA [NV] = '{
        32'h0000_0041, 32'h0000_7931, 32'h0000_0225, 32'h0000_8030,
        32'hDEAD_BEEF, 32'h1111_2222, 32'h1234_07AB, 32'hCAFE_0001};
    localparam logic V_IRQ [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic V_ERR [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    logic        clk = 1'b0, rst = 1'b1;
    logic        cfg_msi_en = 1'b1;
    logic [31:0] cfg_win_hi = 32'h0;
    logic [11:0] cfg_win_lo = 12'hFEE;
    logic        in_valid = 1'b0, in_ready;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        irq_valid, irq_ready = 1'b1;
    logic [63:0] irq_info;
    logic        mw_valid, mw_ready = 1'b1;
    logic [63:0] mw_addr;
    logic [31:0] mw_data;
    logic        fmt_err;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_irq_xlate dut_i (.*);

    function automatic logic [63:0] exp_info(input logic [63:0] a, input logic [31:0] d);
        logic [63:0] r = '0;
        r[23:16] = d[7:0];      r[15:8] = a[19:12];
        r[39:32] = a[11:4];     r[50:40] = a[30:20];
        r[51]    = a[3];        r[55:52] = d[14:11];
        r[6]     = a[2];        r[5]     = d[15];
        r[4:2]   = d[10:8];     r[31:24] = 8'hF8;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // present one write; returns after acceptance, at the following negedge
    task automatic send(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        in_addr = a; in_data = d; in_valid = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        chk(!irq_valid && !mw_valid && !fmt_err && in_ready, "R7 reset",
            {irq_valid, mw_valid, fmt_err, in_ready}, 64'h1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            send(V_ADDR[i], V_DATA[i]);
            chk(irq_valid == V_IRQ[i] && mw_valid == !V_IRQ[i], "R1/R2 class",
                {irq_valid, mw_valid}, {V_IRQ[i], !V_IRQ[i]});
            if (V_IRQ[i]) begin
                chk(irq_info == exp_info(V_ADDR[i], V_DATA[i]), "R3/R4 info",
                    irq_info, exp_info(V_ADDR[i], V_DATA[i]));
                chk(fmt_err == V_ERR[i], "R5 err flag", fmt_err, V_ERR[i]);
            end else begin
                chk(mw_addr == V_ADDR[i] && mw_data == V_DATA[i], "R2 passthru",
                    mw_addr ^ V_ADDR[i], {32'h0, mw_data ^ V_DATA[i]});
            end
            @(negedge clk);
            chk(!fmt_err, "R5 one cycle", fmt_err, 0);
        end

        // R1: enable off turns a window hit into a posted write
        cfg_msi_en = 1'b0;
        send(64'h0000_0000_FEE0_1000, 32'h0000_0030);
        chk(mw_valid && !irq_valid && mw_addr == 64'h0000_0000_FEE0_1000, "R1 enable off",
            mw_addr, 64'h0000_0000_FEE0_1000);
        cfg_msi_en = 1'b1;
        @(negedge clk);

        // R6 back-pressure on the interrupt slot
        irq_ready = 1'b0;
        send(64'h0000_0000_FEE3_0000, 32'h0000_0051);
        in_addr = 64'h0000_0000_FEE4_0000; in_data = 32'h0000_0052; in_valid = 1'b1;
        #1;
        chk(!in_ready, "R6 irq stall", in_ready, 0);
        repeat (2) @(negedge clk);
        chk(irq_valid && irq_info == exp_info(64'h0000_0000_FEE3_0000, 32'h0000_0051),
            "R6 held word", irq_info, exp_info(64'h0000_0000_FEE3_0000, 32'h0000_0051));
        in_addr = 64'h0000_0000_1234_5678; in_data = 32'h0BAD_F00D;
        #1;
        chk(in_ready, "R6 other output open", in_ready, 1);
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
        chk(mw_valid && mw_data == 32'h0BAD_F00D, "R6 posted passes", mw_data, 32'h0BAD_F00D);
        chk(irq_valid, "R6 irq still held", irq_valid, 1);

        // R8 drain and refill in the same cycle
        in_addr = 64'h0000_0000_FEE4_0000; in_data = 32'h0000_0052; in_valid = 1'b1;
        irq_ready = 1'b1;
        #1;
        chk(in_ready, "R8 refill ready", in_ready, 1);
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
        chk(irq_valid && irq_info == exp_info(64'h0000_0000_FEE4_0000, 32'h0000_0052),
            "R8 new word", irq_info, exp_info(64'h0000_0000_FEE4_0000, 32'h0000_0052));
        @(negedge clk);
        chk(!irq_valid, "R8 drained", irq_valid, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule